// File: doc/BRIEF.md
# Event-Triggered Pattern Output Register

This block drives a bank of pattern output bits, arranged in groups of four. Software stages the next value of every output in a next-value register before the event happens. Each group is tied to one of several timer compare-match strobes. When the chosen strobe pulses, every output bit of that group whose enable bit is set takes its staged value. Bits whose enable is clear keep their value. This gives glitch-free, cycle-exact pattern steps without needing the CPU at the moment of the event.

The block has a byte-wide register port. It is a plain control interface with no back-pressure. A write completes in the cycle that `bus_wr` is high. A read is combinational from `bus_addr`, so no handshake is needed or offered. With the default of three groups, the address map is:

| Address | Contents |
|---|---|
| 0 | Next values, bits 7..0 |
| 1 | Next values, bits 11..8 in positions 3..0 |
| 2 | Enables, bits 7..0 |
| 3 | Enables, bits 11..8 in positions 3..0 |
| 4 | Output register, bits 7..0 |
| 5 | Output register, bits 11..8 in positions 3..0 |
| 6 | Trigger select, group g in bits 2g+1..2g |

Two standby inputs change the behaviour. Hardware standby clears the enables. Software standby only blocks the strobes and keeps all stored contents.

Top module: `pattern_out_reg`

## Requirements
- R1: After reset, the next-value, enable and output registers are all 0, and every trigger-select field is 3. Reading address 6 gives 0xFF, and reading addresses 1, 3 and 5 gives 0xF0.
- R2: A pulse on `cm_pulse[s]`, where s is a group's select field, copies the next-value bit into the output bit for every enabled bit of that group. The new value shows on `pat_out` after the next rising clock edge.
- R3: An output bit whose enable bit is 0 keeps its value when its group's trigger fires.
- R4: A pulse on a strobe that a group has not selected leaves that group's outputs unchanged.
- R5: If a bus write to a next-value byte and a trigger land in the same cycle, the transfer uses the value the register held before the write.
- R6: A bus write to an output byte (address 4 or 5) sets those output bits directly. If a trigger hits an enabled bit in the same cycle, the trigger value wins for that bit. Disabled bits take the written value.
- R7: While `hw_stby` is 1, all enable bits are 0 from the next edge on, bus writes to the enables have no effect, and strobes cause no transfer.
- R8: While `sw_stby` is 1, strobes cause no transfer, and the enable, next-value and output registers keep their contents.
- R9: Bits 7..4 of addresses 1, 3 and 5 and bits 7..6 of address 6 read as 1 and ignore writes. Addresses 7 and above read 0xFF and ignore writes.
- R10: Reading an address 0..6 returns the current stored value at the positions given in the address map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cm_pulse | input | 4 | Single-cycle compare-match strobes, one per timer channel |
| hw_stby | input | 1 | Hardware standby; clears the enables |
| sw_stby | input | 1 | Software standby; blocks the strobes, keeps contents |
| pat_out | output | 12 | Pattern output register value |

## Verification
Two functions can fall in the same cycle: a trigger transfer, and a bus write to the next-value bytes or the output bytes. The bench provokes this on purpose. It pulses a selected strobe in the same cycle that it rewrites the staged byte or writes the output byte directly. It also lets the random stream produce such overlaps many times. Each result is judged against a bench model. In that model the transfer takes the pre-write staged bit and overrides a direct write on enabled bits. On disabled bits, the direct write stands.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int GRP_W  = 4;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(input int nbits);
    return (nbits + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/tpo_group.sv
// One group of four pattern bits: staged value, enables, output and trigger select.
module tpo_group
  import tpo_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int SELW = 2,
  parameter logic [SELW-1:0] SEL_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             trig_ok,
  input  logic [NCH-1:0]   cm,
  input  logic [GRP_W-1:0] ndr_we,
  input  logic [GRP_W-1:0] ndr_wd,
  input  logic [GRP_W-1:0] en_we,
  input  logic [GRP_W-1:0] en_wd,
  input  logic [GRP_W-1:0] out_we,
  input  logic [GRP_W-1:0] out_wd,
  input  logic             sel_we,
  input  logic [SELW-1:0]  sel_wd,
  output logic [GRP_W-1:0] ndr_q,
  output logic [GRP_W-1:0] en_q,
  output logic [GRP_W-1:0] out_q,
  output logic [SELW-1:0]  sel_q
);
  logic fire;
  assign fire = trig_ok && cm[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RST;
    else if (sel_we) sel_q <= sel_wd;
  end

  for (genvar j = 0; j < GRP_W; j++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ndr_q[j] <= 1'b0;
        en_q[j]  <= 1'b0;
        out_q[j] <= 1'b0;
      end else begin
        if (ndr_we[j]) ndr_q[j] <= ndr_wd[j];
        if (hw_stby) en_q[j] <= 1'b0;
        else if (en_we[j]) en_q[j] <= en_wd[j];
        // trigger transfer uses the staged value before any same-cycle write
        if (fire && en_q[j]) out_q[j] <= ndr_q[j];
        else if (out_we[j]) out_q[j] <= out_wd[j];
      end
    end
  end
endmodule

// File: rtl/tpo_bus_map.sv
// Register-port decode: per-bit write strobes and the read-back mux.
module tpo_bus_map
  import tpo_pkg::*;
#(
  parameter int NGROUPS = 3,
  parameter int SELW    = 2,
  parameter int AW      = 4
) (
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  input  logic [GRP_W*NGROUPS-1:0] ndr_q,
  input  logic [GRP_W*NGROUPS-1:0] en_q,
  input  logic [GRP_W*NGROUPS-1:0] out_q,
  input  logic [SELW*NGROUPS-1:0]  sel_q,
  output logic [GRP_W*NGROUPS-1:0] ndr_we,
  output logic [GRP_W*NGROUPS-1:0] en_we,
  output logic [GRP_W*NGROUPS-1:0] out_we,
  output logic [GRP_W*NGROUPS-1:0] bit_wd,
  output logic [NGROUPS-1:0]       sel_we,
  output logic [SELW*NGROUPS-1:0]  sel_wd,
  output logic [BYTE_W-1:0]        bus_rdata
);
  localparam int NBITS     = GRP_W * NGROUPS;
  localparam int NBYTES    = bytes_for(NBITS);
  localparam int NDR_BASE  = 0;
  localparam int EN_BASE   = NBYTES;
  localparam int OUT_BASE  = 2 * NBYTES;
  localparam int TSEL_BASE = 3 * NBYTES;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign ndr_we[i] = bus_wr && (bus_addr == AW'(NDR_BASE + i / BYTE_W));
    assign en_we[i]  = bus_wr && (bus_addr == AW'(EN_BASE + i / BYTE_W));
    assign out_we[i] = bus_wr && (bus_addr == AW'(OUT_BASE + i / BYTE_W));
    assign bit_wd[i] = bus_wdata[i % BYTE_W];
  end

  // select fields never straddle a byte because SELW divides the byte width
  for (genvar g = 0; g < NGROUPS; g++) begin : g_sel
    assign sel_we[g] = bus_wr && (bus_addr == AW'(TSEL_BASE + (g * SELW) / BYTE_W));
    assign sel_wd[g*SELW +: SELW] = bus_wdata[(g*SELW) % BYTE_W +: SELW];
  end

  always_comb begin
    bus_rdata = '1;
    for (int i = 0; i < NBITS; i++) begin
      if (bus_addr == AW'(NDR_BASE + i / BYTE_W)) bus_rdata[i % BYTE_W] = ndr_q[i];
      if (bus_addr == AW'(EN_BASE + i / BYTE_W))  bus_rdata[i % BYTE_W] = en_q[i];
      if (bus_addr == AW'(OUT_BASE + i / BYTE_W)) bus_rdata[i % BYTE_W] = out_q[i];
    end
    for (int k = 0; k < SELW * NGROUPS; k++) begin
      if (bus_addr == AW'(TSEL_BASE + k / BYTE_W)) bus_rdata[k % BYTE_W] = sel_q[k];
    end
  end
endmodule

// File: rtl/pattern_out_reg.sv
module pattern_out_reg
  import tpo_pkg::*;
#(
  parameter int NGROUPS = 3,
  parameter int NCH     = 4,
  parameter int AW      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  input  logic [NCH-1:0]           cm_pulse,
  input  logic                     hw_stby,
  input  logic                     sw_stby,
  output logic [GRP_W*NGROUPS-1:0] pat_out
);
  localparam int NBITS = GRP_W * NGROUPS;
  localparam int SELW  = $clog2(NCH);

  logic [NBITS-1:0]        ndr_q, en_q, out_q;
  logic [NBITS-1:0]        ndr_we, en_we, out_we, bit_wd;
  logic [NGROUPS-1:0]      sel_we;
  logic [SELW*NGROUPS-1:0] sel_wd, sel_q;
  logic                    trig_ok;

  assign trig_ok = !sw_stby && !hw_stby;
  assign pat_out = out_q;

  tpo_bus_map #(.NGROUPS(NGROUPS), .SELW(SELW), .AW(AW)) u_map (
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ndr_q(ndr_q), .en_q(en_q), .out_q(out_q), .sel_q(sel_q),
    .ndr_we(ndr_we), .en_we(en_we), .out_we(out_we), .bit_wd(bit_wd),
    .sel_we(sel_we), .sel_wd(sel_wd), .bus_rdata(bus_rdata)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    tpo_group #(.NCH(NCH), .SELW(SELW), .SEL_RST(SELW'(NCH - 1))) u_grp (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .trig_ok(trig_ok),
      .cm(cm_pulse),
      .ndr_we(ndr_we[g*GRP_W +: GRP_W]), .ndr_wd(bit_wd[g*GRP_W +: GRP_W]),
      .en_we(en_we[g*GRP_W +: GRP_W]),   .en_wd(bit_wd[g*GRP_W +: GRP_W]),
      .out_we(out_we[g*GRP_W +: GRP_W]), .out_wd(bit_wd[g*GRP_W +: GRP_W]),
      .sel_we(sel_we[g]), .sel_wd(sel_wd[g*SELW +: SELW]),
      .ndr_q(ndr_q[g*GRP_W +: GRP_W]), .en_q(en_q[g*GRP_W +: GRP_W]),
      .out_q(out_q[g*GRP_W +: GRP_W]), .sel_q(sel_q[g*SELW +: SELW])
    );
  end
endmodule

// File: rtl/pattern_out_reg_chk.sv
module pattern_out_reg_chk
  import tpo_pkg::*;
#(
  parameter int NGROUPS = 3,
  parameter int NCH     = 4,
  parameter int AW      = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [AW-1:0]            bus_addr,
  input logic [BYTE_W-1:0]        bus_rdata,
  input logic [NCH-1:0]           cm_pulse,
  input logic                     hw_stby,
  input logic                     sw_stby,
  input logic [GRP_W*NGROUPS-1:0] pat_out,
  input logic [GRP_W*NGROUPS-1:0] en_q,
  input logic [GRP_W*NGROUPS-1:0] ndr_q
);
  localparam int NBITS    = GRP_W * NGROUPS;
  localparam int NBYTES   = bytes_for(NBITS);
  localparam int OUT_BASE = 2 * NBYTES;
  localparam int MAP_END  = 3 * NBYTES + bytes_for($clog2(NCH) * NGROUPS);

  logic out_write;
  assign out_write = bus_wr && (bus_addr >= AW'(OUT_BASE)) && (bus_addr < AW'(OUT_BASE + NBYTES));

  p_hw_clears_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (en_q == '0));

  p_disabled_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_write |=> (((pat_out ^ $past(pat_out)) & ~$past(en_q)) == '0));

  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !bus_wr) |=> ($stable(pat_out) && $stable(en_q) && $stable(ndr_q)));

  p_no_strobe_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm_pulse == '0) && !out_write) |=> $stable(pat_out));

  always_comb begin
    if (rst_n && (int'(bus_addr) >= MAP_END)) begin
      p_unmapped_ff_r9: assert (bus_rdata == 8'hFF);
    end
  end
endmodule

bind pattern_out_reg pattern_out_reg_chk #(.NGROUPS(NGROUPS), .NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .cm_pulse(cm_pulse), .hw_stby(hw_stby),
  .sw_stby(sw_stby), .pat_out(pat_out), .en_q(en_q), .ndr_q(ndr_q)
);

// File: tb/sim_pattern_out_reg.sv
`timescale 1ns/1ps
module sim_pattern_out_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  cm_pulse = '0;
  logic        hw_stby = 1'b0;
  logic        sw_stby = 1'b0;
  logic [11:0] pat_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_ndr = '0, m_en = '0, m_out = '0;
  logic [5:0]  m_sel = 6'h3F;

  always #4 clk = ~clk;

  pattern_out_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cm_pulse(cm_pulse),
    .hw_stby(hw_stby), .sw_stby(sw_stby), .pat_out(pat_out)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ndr[7:0];
      4'd1: return {4'hF, m_ndr[11:8]};
      4'd2: return m_en[7:0];
      4'd3: return {4'hF, m_en[11:8]};
      4'd4: return m_out[7:0];
      4'd5: return {4'hF, m_out[11:8]};
      4'd6: return {2'b11, m_sel};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus and checks pat_out
  task automatic step(input string tag, input logic wr, input logic [3:0] a,
                      input logic [7:0] wd, input logic [3:0] cm,
                      input logic hw, input logic sw);
    logic [11:0] n_ndr, n_en, n_out;
    logic [5:0]  n_sel;
    bus_wr = wr; bus_addr = a; bus_wdata = wd; cm_pulse = cm;
    hw_stby = hw; sw_stby = sw;
    n_ndr = m_ndr; n_en = m_en; n_out = m_out; n_sel = m_sel;
    for (int i = 0; i < 12; i++) begin
      logic fire;
      fire = !sw && !hw && cm[m_sel[2*(i/4) +: 2]];
      if (wr && a == 4'(i / 8)) n_ndr[i] = wd[i % 8];
      if (hw) n_en[i] = 1'b0;
      else if (wr && a == 4'(2 + i / 8)) n_en[i] = wd[i % 8];
      if (fire && m_en[i]) n_out[i] = m_ndr[i];
      else if (wr && a == 4'(4 + i / 8)) n_out[i] = wd[i % 8];
    end
    if (wr && a == 4'd6) n_sel = wd[5:0];
    @(posedge clk);
    m_ndr = n_ndr; m_en = n_en; m_out = n_out; m_sel = n_sel;
    @(negedge clk);
    check(tag, {4'h0, pat_out}, {4'h0, m_out});
    bus_wr = 1'b0; cm_pulse = '0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    bus_wr = 1'b0; bus_addr = a; cm_pulse = '0;
    #1;
    check(tag, {8'h0, bus_rdata}, {8'h0, exp_read(a)});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", {4'h0, pat_out}, 16'h0);
    for (int a = 0; a < 7; a++) rd("R1", 4'(a));
    // R2 group0 on channel 1, others on 3
    step("R10", 1, 4'd6, 8'hFD, 4'h0, 0, 0);
    rd("R10", 4'd6);
    step("R10", 1, 4'd0, 8'hA5, 4'h0, 0, 0);
    step("R10", 1, 4'd2, 8'hFF, 4'h0, 0, 0);
    step("R2", 0, 4'd0, 8'h00, 4'b0010, 0, 0);
    check("R2", {4'h0, pat_out}, 16'h005);
    // R4 channel 3 fires groups 1 and 2; group 2 disabled
    step("R4", 0, 4'd0, 8'h00, 4'b0100, 0, 0);
    check("R4", {4'h0, pat_out}, 16'h005);
    step("R4", 0, 4'd0, 8'h00, 4'b1000, 0, 0);
    check("R4", {4'h0, pat_out}, 16'h0A5);
    // R3 partial enable
    step("R3", 1, 4'd0, 8'h5A, 4'h0, 0, 0);
    step("R3", 1, 4'd2, 8'h0F, 4'h0, 0, 0);
    step("R3", 0, 4'd0, 8'h00, 4'b1010, 0, 0);
    check("R3", {4'h0, pat_out}, 16'h0AA);
    // R5 same-cycle staged write and trigger
    step("R5", 1, 4'd0, 8'h00, 4'b0010, 0, 0);
    check("R5", {4'h0, pat_out}, 16'h0AA);
    step("R5", 0, 4'd0, 8'h00, 4'b0010, 0, 0);
    check("R5", {4'h0, pat_out}, 16'h0A0);
    // R6 direct write against trigger
    step("R6", 1, 4'd0, 8'hFF, 4'h0, 0, 0);
    step("R6", 1, 4'd4, 8'h00, 4'b0010, 0, 0);
    check("R6", {4'h0, pat_out}, 16'h00F);
    // R7 hardware standby
    step("R7", 1, 4'd2, 8'hFF, 4'h0, 1, 0);
    rd("R7", 4'd2);
    step("R7", 0, 4'd0, 8'h00, 4'b1111, 1, 0);
    check("R7", {4'h0, pat_out}, 16'h00F);
    // R8 software standby keeps enables, blocks strobes
    step("R8", 1, 4'd2, 8'hF0, 4'h0, 0, 0);
    step("R8", 0, 4'd0, 8'h00, 4'b1111, 0, 1);
    rd("R8", 4'd2);
    check("R8", {4'h0, pat_out}, 16'h00F);
    // R9 reserved bits and unmapped addresses
    step("R9", 1, 4'd1, 8'hFF, 4'h0, 0, 0);
    rd("R9", 4'd1);
    step("R9", 1, 4'd9, 8'h00, 4'h0, 0, 0);
    rd("R9", 4'd9);
    rd("R9", 4'd15);
    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [3:0] cmv;
      cmv = 4'd0;
      if ($urandom_range(2) == 0) cmv[$urandom_range(3)] = 1'b1;
      step("R3", ($urandom_range(1) == 1), 4'($urandom_range(8)), 8'($urandom),
           cmv, ($urandom_range(39) == 0), ($urandom_range(19) == 0));
      if (n % 8 == 0) rd("R10", 4'($urandom_range(7)));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule